// File: doc/BRIEF.md
# Pin Multiplexing and Direction Controller for a Twelve-Pin I/O Bank

This block holds one small control word per pin for twelve general-purpose pins, grouped as three ports of four. From each word, and from a few signals of a neighbouring serial unit and oscillator monitor, it works out each pin's effective drive enable, the value driven and the input termination: a pull resistor or a high-impedance input. Five pins can be handed to another function, and that choice overrides the direction the pin was programmed with. The serial data input is one such pin. Three are fixed outputs: serial data out, data ready and the oscillator monitor clock. The transfer clock pin turns in either direction, following an external-clock select from the serial unit.

Software reaches the block through a flat register bus. Writing an address loads a pin's control word or a port's output latch. Every clock the registered read port returns the word at the presented address, and a port address reads back the value currently seen on that port's pins.

Top module: `gpio_altfn_ctrl`

## Requirements
- R1: Synchronous reset clears every control word and every output latch. After reset every pin is an input (`pin_oe` 0) with the pull resistor on (`pull_en` 1, `hiz_sel` 0), `pin_out` is 0 and `bus_rdata` is 0.
- R2: The control word of pin n is at address n, where n = 4·port_index + bit: port 2 is at 0–3, port 3 at 4–7 and port 4 at 8–11. A write stores `bus_wdata[2:0]` on the clock edge. The read data is registered: one cycle after an address is presented, `bus_rdata` holds that word zero-extended to 4 bits.
- R3: Control word bit 1 is the direction (1 = output). When no secondary function overrides it, an output pin has `pin_oe` 1. `pin_out` equals the pin's output latch bit, whatever the direction.
- R4: Bit 0 sets the termination of a pin that is effectively an input: 0 gives `pull_en` 1 and 1 gives `hiz_sel` 1. When a pin is effectively an output, both are 0.
- R5: Pins 0–6 have no secondary function. Bit 2 has no effect on them, and they never feed a secondary input.
- R6: Pin 7 (port 3 bit 3) with bit 2 set is an input whatever bit 1 says, and `ser_din` follows `pin_in[7]`. When bit 2 is clear, `ser_din` is 0.
- R7: Pins 8, 9 and 11 with bit 2 set are outputs whatever bit 1 says. They drive `ser_dout`, `ser_rdy` and `osc_mon` respectively.
- R8: Pin 10 with bit 2 set follows `ext_clk_sel`. When it is 0 the pin is an output driving `ser_clk_out` and `ser_clk_in` is 0. When it is 1 the pin is an input and `ser_clk_in` follows `pin_in[10]`. When bit 2 is clear, `ser_clk_in` is 0.
- R9: Addresses 12, 13 and 14 hold the output latches of ports 2, 3 and 4. A write stores `bus_wdata[3:0]`, with bit k going to pin bit k. A read returns, for each bit, `pin_out` if that pin is effectively an output and `pin_in` otherwise.
- R10: Address 15 is unmapped. A write there changes nothing and a read returns 0.
- R11: A control word reads back exactly as written, not as the effective direction. For example, pin 7 written with 3'b110 reads 4'h6 while it acts as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data |
| pin_in | input | 12 | Values seen at the pins |
| pin_oe | output | 12 | Per-pin drive enable |
| pin_out | output | 12 | Per-pin driven value |
| pull_en | output | 12 | Pull resistor enable |
| hiz_sel | output | 12 | High-impedance input select |
| ser_dout | input | 1 | Serial data to drive on pin 8 |
| ser_rdy | input | 1 | Data-ready flag to drive on pin 9 |
| ser_clk_out | input | 1 | Internal shift clock for pin 10 |
| ext_clk_sel | input | 1 | 1 selects an external transfer clock |
| osc_mon | input | 1 | Oscillator monitor clock for pin 11 |
| ser_din | output | 1 | Serial data taken from pin 7 |
| ser_clk_in | output | 1 | External transfer clock taken from pin 10 |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge. They also assume `ext_clk_sel`, `pin_in` and the serial signals hold steady from one edge to the next, because the checks compare combinational outputs with the inputs sampled at the same edge. The bench changes every input only on the falling edge and holds reset high from time zero, so the assertions see no value from before the first reset. Random stimulus covers all sixteen addresses and every value of the serial and pin inputs. The directed steps put each secondary pin in both directions, and the clock pin under both clock sources.

// File: rtl/gpio_af_pkg.sv
package gpio_af_pkg;

  // control word layout: the pin logic decodes these positions
  localparam int CTRL_W  = 3;
  localparam int CB_ALT  = 2;
  localparam int CB_DIR  = 1;
  localparam int CB_TERM = 0;

  // what a pin does when its secondary function is enabled
  typedef enum logic [1:0] {
    ROLE_PLAIN   = 2'd0,
    ROLE_ALT_IN  = 2'd1,
    ROLE_ALT_OUT = 2'd2,
    ROLE_ALT_CLK = 2'd3
  } pin_role_e;

endpackage

// File: rtl/gpio_af_regs.sv
module gpio_af_regs
  import gpio_af_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int PINS_PER_PORT = 4,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_view,
  output logic [NUM_PORTS*PINS_PER_PORT*CTRL_W-1:0] ctrl_flat,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] latch_flat,
  output logic [DATA_W-1:0]               bus_rdata
);

  localparam int NUM_PINS  = NUM_PORTS * PINS_PER_PORT;
  localparam int DATA_BASE = NUM_PINS;
  localparam int MAP_END   = NUM_PINS + NUM_PORTS;

  logic [CTRL_W-1:0]        ctrl_q  [NUM_PINS];
  logic [PINS_PER_PORT-1:0] latch_q [NUM_PORTS];
  logic [DATA_W-1:0]        rd_next;

  // control words and output latches share one write decoder
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++)  ctrl_q[i]  <= '0;
      for (int p = 0; p < NUM_PORTS; p++) latch_q[p] <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (bus_addr == ADDR_W'(i)) ctrl_q[i] <= bus_wdata[CTRL_W-1:0];
      for (int p = 0; p < NUM_PORTS; p++)
        if (bus_addr == ADDR_W'(DATA_BASE + p)) latch_q[p] <= bus_wdata[PINS_PER_PORT-1:0];
    end
  end

  // flatten for the pin cells
  genvar gi, gp;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_ctrl_out
      assign ctrl_flat[gi*CTRL_W +: CTRL_W] = ctrl_q[gi];
    end
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_latch_out
      assign latch_flat[gp*PINS_PER_PORT +: PINS_PER_PORT] = latch_q[gp];
    end
  endgenerate

  // read selection, registered below
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (bus_addr == ADDR_W'(i)) rd_next = DATA_W'(ctrl_q[i]);
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_addr == ADDR_W'(DATA_BASE + p))
        rd_next = DATA_W'(pad_view[p*PINS_PER_PORT +: PINS_PER_PORT]);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // a control write lands in the addressed word on the next edge
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr < ADDR_W'(NUM_PINS)) |=>
      ctrl_flat[$past(bus_addr)*CTRL_W +: CTRL_W] == $past(bus_wdata[CTRL_W-1:0]));

  // unmapped addresses always read back zero
  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= ADDR_W'(MAP_END)) |=> bus_rdata == '0);

endmodule

// File: rtl/gpio_af_pin.sv
module gpio_af_pin
  import gpio_af_pkg::*;
#(
  parameter pin_role_e ROLE = ROLE_PLAIN
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              latch,
  input  logic              pad_in,
  input  logic              alt_drv,
  input  logic              ext_clk,
  output logic              oe,
  output logic              dout,
  output logic              pull,
  output logic              hiz,
  output logic              alt_in
);

  logic alt_on;

  always_comb begin
    alt_on = ctrl[CB_ALT];
    oe     = ctrl[CB_DIR];
    dout   = latch;
    alt_in = 1'b0;
    unique case (ROLE)
      ROLE_ALT_IN: begin
        if (alt_on) begin
          oe     = 1'b0;
          alt_in = pad_in;
        end
      end
      ROLE_ALT_OUT: begin
        if (alt_on) begin
          oe   = 1'b1;
          dout = alt_drv;
        end
      end
      ROLE_ALT_CLK: begin
        if (alt_on) begin
          if (ext_clk) begin
            oe     = 1'b0;
            alt_in = pad_in;
          end else begin
            oe   = 1'b1;
            dout = alt_drv;
          end
        end
      end
      default: ;
    endcase
    // termination matters only while the pin listens
    pull = !oe && !ctrl[CB_TERM];
    hiz  = !oe &&  ctrl[CB_TERM];
  end

endmodule

// File: rtl/gpio_altfn_ctrl.sv
module gpio_altfn_ctrl
  import gpio_af_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int PINS_PER_PORT = 4,
  parameter int SIN_PIN       = 7,
  parameter int SOUT_PIN      = 8,
  parameter int RDY_PIN       = 9,
  parameter int CLK_PIN       = 10,
  parameter int MON_PIN       = 11,
  parameter int NUM_PINS      = NUM_PORTS * PINS_PER_PORT,
  parameter int ADDR_W        = $clog2(NUM_PINS + NUM_PORTS + 1),
  parameter int DATA_W        = (PINS_PER_PORT > CTRL_W) ? PINS_PER_PORT : CTRL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] hiz_sel,
  input  logic                ser_dout,
  input  logic                ser_rdy,
  input  logic                ser_clk_out,
  input  logic                ext_clk_sel,
  input  logic                osc_mon,
  output logic                ser_din,
  output logic                ser_clk_in
);

  logic [NUM_PINS*CTRL_W-1:0] ctrl_flat;
  logic [NUM_PINS-1:0]        latch_flat;
  logic [NUM_PINS-1:0]        pad_view;
  logic [NUM_PINS-1:0]        alt_drv_vec;
  logic [NUM_PINS-1:0]        alt_in_vec;

  gpio_af_regs #(
    .NUM_PORTS    (NUM_PORTS),
    .PINS_PER_PORT(PINS_PER_PORT),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_view  (pad_view),
    .ctrl_flat (ctrl_flat),
    .latch_flat(latch_flat),
    .bus_rdata (bus_rdata)
  );

  // secondary drive sources, routed to their pins
  always_comb begin
    alt_drv_vec           = '0;
    alt_drv_vec[SOUT_PIN] = ser_dout;
    alt_drv_vec[RDY_PIN]  = ser_rdy;
    alt_drv_vec[CLK_PIN]  = ser_clk_out;
    alt_drv_vec[MON_PIN]  = osc_mon;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      localparam pin_role_e ROLE_I =
        (gi == SIN_PIN) ? ROLE_ALT_IN :
        (gi == CLK_PIN) ? ROLE_ALT_CLK :
        (gi == SOUT_PIN || gi == RDY_PIN || gi == MON_PIN) ? ROLE_ALT_OUT :
        ROLE_PLAIN;
      gpio_af_pin #(.ROLE(ROLE_I)) i_pin (
        .ctrl   (ctrl_flat[gi*CTRL_W +: CTRL_W]),
        .latch  (latch_flat[gi]),
        .pad_in (pin_in[gi]),
        .alt_drv(alt_drv_vec[gi]),
        .ext_clk(ext_clk_sel),
        .oe     (pin_oe[gi]),
        .dout   (pin_out[gi]),
        .pull   (pull_en[gi]),
        .hiz    (hiz_sel[gi]),
        .alt_in (alt_in_vec[gi])
      );
      // port reads see the driven value on outputs and the pad on inputs
      assign pad_view[gi] = pin_oe[gi] ? pin_out[gi] : pin_in[gi];
    end
  endgenerate

  assign ser_din    = alt_in_vec[SIN_PIN];
  assign ser_clk_in = alt_in_vec[CLK_PIN];

  localparam logic [NUM_PINS-1:0] ALT_MASK =
    (NUM_PINS'(1) << SIN_PIN) | (NUM_PINS'(1) << SOUT_PIN) | (NUM_PINS'(1) << RDY_PIN) |
    (NUM_PINS'(1) << CLK_PIN) | (NUM_PINS'(1) << MON_PIN);

  assert_term_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    ((pull_en & hiz_sel) == '0) && ((pin_oe & (pull_en | hiz_sel)) == '0));

  assert_plain_no_alt_R5: assert property (@(posedge clk) disable iff (rst)
    (alt_in_vec & ~ALT_MASK) == '0);

  assert_sin_forced_in_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_flat[SIN_PIN*CTRL_W + CB_ALT] |-> (!pin_oe[SIN_PIN] && ser_din == pin_in[SIN_PIN]));

  assert_sout_forced_out_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_flat[SOUT_PIN*CTRL_W + CB_ALT] |-> (pin_oe[SOUT_PIN] && pin_out[SOUT_PIN] == ser_dout));

  assert_clk_dir_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_flat[CLK_PIN*CTRL_W + CB_ALT] |-> (pin_oe[CLK_PIN] == !ext_clk_sel));

endmodule

// File: tb/test_gpio_altfn_ctrl.sv
module test_gpio_altfn_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic [3:0]  bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_oe, pin_out, pull_en, hiz_sel;
  logic        ser_dout = 0, ser_rdy = 0, ser_clk_out = 0, ext_clk_sel = 0, osc_mon = 0;
  logic        ser_din, ser_clk_in;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  gpio_altfn_ctrl i_gpio_altfn_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .hiz_sel(hiz_sel), .ser_dout(ser_dout), .ser_rdy(ser_rdy),
    .ser_clk_out(ser_clk_out), .ext_clk_sel(ext_clk_sel), .osc_mon(osc_mon),
    .ser_din(ser_din), .ser_clk_in(ser_clk_in)
  );

  // behavioural reference state
  logic [2:0] m_ctrl [12];
  bit         m_lat  [12];
  logic [3:0] exp_rdata = '0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    $display("FAIL watchdog: run did not finish (actual running, expected done)");
    miscompares++;
    finish_run();
  end

  // effective behaviour of pin i from the requirements
  task automatic eff(input int i, output bit oe, output bit o, output bit pl,
                     output bit hz, output bit ain);
    bit alt = m_ctrl[i][2];
    oe = m_ctrl[i][1]; o = m_lat[i]; ain = 0;
    if (alt) begin
      case (i)
        7:  begin oe = 0; ain = pin_in[7]; end               // R6
        8:  begin oe = 1; o = ser_dout; end                  // R7
        9:  begin oe = 1; o = ser_rdy; end                   // R7
        11: begin oe = 1; o = osc_mon; end                   // R7
        10: if (ext_clk_sel) begin oe = 0; ain = pin_in[10]; end
            else begin oe = 1; o = ser_clk_out; end          // R8
        default: ;                                           // R5: bit 2 ignored
      endcase
    end
    pl = !oe && !m_ctrl[i][0];                               // R4
    hz = !oe &&  m_ctrl[i][0];
  endtask

  function automatic string tag(int i);
    if (rst) return "R1";
    if (m_ctrl[i][2] && i == 7) return "R6";
    if (m_ctrl[i][2] && (i == 8 || i == 9 || i == 11)) return "R7";
    if (m_ctrl[i][2] && i == 10) return "R8";
    if (m_ctrl[i][2]) return "R5";
    return "R3";
  endfunction

  task automatic cmp(string req, string what, int act, int expv);
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic compare_all();
    bit oe, o, pl, hz, ain;
    bit exp_din = 0, exp_cin = 0;
    vectors++;
    for (int i = 0; i < 12; i++) begin
      eff(i, oe, o, pl, hz, ain);
      cmp(tag(i), $sformatf("pin_oe[%0d]", i), pin_oe[i], oe);
      cmp(tag(i), $sformatf("pin_out[%0d]", i), pin_out[i], o);
      cmp(rst ? "R1" : "R4", $sformatf("pull_en[%0d]", i), pull_en[i], pl);
      cmp(rst ? "R1" : "R4", $sformatf("hiz_sel[%0d]", i), hiz_sel[i], hz);
      if (i == 7)  exp_din = ain;
      if (i == 10) exp_cin = ain;
    end
    cmp("R6", "ser_din", ser_din, exp_din);
    cmp("R8", "ser_clk_in", ser_clk_in, exp_cin);
  endtask

  // one clock: drive at the falling edge, model the rising edge, check just after
  task automatic step(input bit wr, input logic [3:0] a, input logic [3:0] d);
    string rtag;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    rtag = rst ? "R1" : (a < 12) ? "R2" : (a < 15) ? "R9" : "R10";
    if (rst) exp_rdata = '0;
    else if (a < 12) exp_rdata = {1'b0, m_ctrl[a]};
    else if (a < 15) begin
      for (int b = 0; b < 4; b++) begin
        bit oe, o, pl, hz, ain;
        eff((a - 12) * 4 + b, oe, o, pl, hz, ain);
        exp_rdata[b] = oe ? o : pin_in[(a - 12) * 4 + b];
      end
    end else exp_rdata = '0;
    if (rst) begin
      for (int i = 0; i < 12; i++) begin m_ctrl[i] = '0; m_lat[i] = 0; end
    end else if (wr) begin
      if (a < 12) m_ctrl[a] = d[2:0];
      else if (a < 15) for (int b = 0; b < 4; b++) m_lat[(a - 12) * 4 + b] = d[b];
    end
    #1;
    compare_all();
    cmp(rtag, $sformatf("bus_rdata @%0d", a), bus_rdata, exp_rdata);
  endtask

  initial begin
    for (int i = 0; i < 12; i++) begin m_ctrl[i] = '0; m_lat[i] = 0; end
    // R1: reset state
    repeat (3) step(0, 4'd0, 4'd0);
    @(negedge clk); rst = 0;
    step(0, 4'd0, 4'd0);
    // R3 / R9: pin 2 as output driving its latch
    step(1, 4'd2, 4'b0010);
    step(1, 4'd12, 4'b0100);
    step(0, 4'd12, 4'd0);
    // R4: high-impedance input on pin 5
    step(1, 4'd5, 4'b001);
    // R5: bit 2 on a plain input pin has no effect
    step(1, 4'd3, 4'b100);
    // R6 / R11: pin 7 forced input though bit 1 set; readback shows the stored word
    pin_in = 12'h080;
    step(1, 4'd7, 4'b110);
    step(0, 4'd7, 4'd0);
    pin_in = 12'h000;
    step(0, 4'd13, 4'd0);
    // R7: fixed secondary outputs
    ser_dout = 1; osc_mon = 1;
    step(1, 4'd8, 4'b100);
    step(1, 4'd9, 4'b101);
    step(1, 4'd11, 4'b100);
    step(0, 4'd14, 4'd0);
    // R8: clock pin under internal then external clock
    ser_clk_out = 1;
    step(1, 4'd10, 4'b100);
    ext_clk_sel = 1; pin_in = 12'h400;
    step(0, 4'd14, 4'd0);
    // R10: unmapped address
    step(1, 4'd15, 4'hF);
    step(0, 4'd15, 4'd0);
    // randomised traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pin_in = 12'($urandom); ser_dout = 1'($urandom); ser_rdy = 1'($urandom);
      ser_clk_out = 1'($urandom); ext_clk_sel = 1'($urandom); osc_mon = 1'($urandom);
      step(1'($urandom), 4'($urandom), 4'($urandom));
    end
    finish_run();
  end

endmodule